// File: doc/BRIEF.md
# Control-Transfer Sequencer

This block steps through the control-flow instructions of a small 8-bit processor with a 16-bit program counter and a 16-bit stack pointer. It handles absolute jump, relative jump, call, return, return-from-interrupt, fixed-vector restart and jump-through-HL. It runs one machine cycle per clock. In each machine cycle it drives a single byte-wide bus operation: a read, a write, or an internal idle cycle. Reads that fetch operands use the program counter as the address. Stack accesses use the stack pointer.

The surrounding core presents a decoded operation, a condition selector, the zero and carry flags, and the current PC, SP and HL, then pulses `start`. The sequencer captures all of these and runs the bus cycles that the operation and the condition outcome call for. It marks the last cycle with `done`. From the following cycle it holds the new PC and SP on `pc_out` and `sp_out`. A return-from-interrupt also sets the sticky interrupt-enable output.

The state machine has these states:

- `ST_IDLE`: waits for `start`.
- `ST_COND`: the internal condition-test cycle of a conditional return.
- `ST_OPLO` and `ST_OPHI`: read the low and high operand bytes from the instruction stream.
- `ST_STKLO` and `ST_STKHI`: pop the low and high target bytes from the stack.
- `ST_PREP`: the internal cycle before a push.
- `ST_PUSHH` and `ST_PUSHL`: write the return-address bytes.
- `ST_FIN`: the closing internal cycle that loads the jump or return target.
- `ST_HLJ`: the single cycle of the jump through HL.

The transitions are:

- IDLE→OPLO for a jump, a relative jump or a call.
- IDLE→COND for a conditional return.
- IDLE→STKLO for an unconditional return or a return-from-interrupt.
- IDLE→PREP for a restart.
- IDLE→HLJ for a jump through HL.
- OPLO→FIN for a taken relative jump.
- OPLO→IDLE for a relative jump that is not taken.
- OPLO→OPHI for a jump or a call.
- OPHI→FIN for a taken jump.
- OPHI→PREP for a taken call.
- OPHI→IDLE when the condition fails.
- COND→STKLO when the condition holds.
- COND→IDLE when it fails.
- STKLO→STKHI→FIN→IDLE.
- PREP→PUSHH→PUSHL→IDLE.
- HLJ→IDLE.

Top module: `ctl_xfer_seq`

## Requirements
- R1: `cond` selects the branch test: 0 always, 1 carry set, 2 zero set, 3 carry clear, 4 zero clear. Codes 5 to 7 also mean always. The flags are sampled in the cycle `start` is accepted, and the test applies to jump, relative jump, call and return.
- R2: `op` encodes 0 jump, 1 relative jump, 2 call, 3 return, 4 return-from-interrupt, 5 restart, 6 jump-through-HL. A `start` is accepted only while `busy` is low and `op` is 0 to 6. A `start` with `op`=7, or one that arrives while busy, has no effect on the bus or on the results.
- R3: An absolute jump reads the low byte at PC and then the high byte at PC+1, and forms the target as high<<8 | low. When taken it adds one idle cycle and loads the target (3 cycles). When not taken it ends after the reads with PC = PC+2 (2 cycles).
- R4: A relative jump reads one byte at PC. When taken it adds one idle cycle and sets PC to PC+1 plus that byte, sign-extended (2 cycles). When not taken it gives PC+1 after a single cycle.
- R5: A taken call reads two target bytes and then runs one idle cycle. It writes (PC+2) high byte to SP-1, then the low byte to SP-2, leaves SP-2 and loads the target, in the cycle order read, read, idle, write, write. A call that is not taken ends after the two reads with PC+2 and SP unchanged.
- R6: A conditional return starts with one idle test cycle and ends there when the condition fails. A taken return, conditional or not, reads the low byte at SP and the high byte at SP+1, adds 2 to SP and ends with one idle cycle that loads the target. The unconditional return takes 3 cycles and the taken conditional return takes 4.
- R7: The return-from-interrupt form runs exactly like the unconditional return and also sets `irq_en`. `irq_en` then stays at 1 until reset.
- R8: A restart runs idle, write, write. It pushes the captured PC high byte to SP-1 and the low byte to SP-2, leaves SP-2, and loads PC with `vec_sel`×8.
- R9: Jump-through-HL takes a single idle cycle, loads PC from `hl_in` and leaves SP unchanged.
- R10: `bus_kind` encodes 0 idle, 1 read and 2 write. `done` is high in the last cycle of every instruction. `pc_out` and `sp_out` show the results from the next cycle on. After reset `busy`, `done`, `bus_kind`, `irq_en`, `pc_out` and `sp_out` are all zero.
- R11: All stack and program-counter arithmetic wraps modulo 2^16, so a push from SP=0x0001 writes 0x0000 and then 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one machine cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Requests a new instruction while idle |
| op | input | 3 | Operation code (R2) |
| cond | input | 3 | Condition selector (R1) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| vec_sel | input | 3 | Restart vector index |
| pc_in | input | 16 | PC just past the opcode |
| sp_in | input | 16 | Current stack pointer |
| hl_in | input | 16 | HL register pair |
| bus_rdata | input | 8 | Read data, valid in a read cycle |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_kind | output | 2 | Cycle type (R10) |
| done | output | 1 | Last cycle of the instruction |
| busy | output | 1 | An instruction is in progress |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 16 | Resulting stack pointer |
| irq_en | output | 1 | Interrupt enable, set by return-from-interrupt |

## Verification
The cases that are hardest to reach from the ports are a second `start` arriving in the middle of a multi-cycle sequence, and a push that crosses address zero.

- **Mid-sequence start:** the bench raises `start` with a different operation during the second cycle of a jump. It then checks that the cycle trace and the final PC match an undisturbed jump.
- **Push across zero:** the bench issues a call from SP=0x0001. It checks that the high byte lands at 0x0000, the low byte lands at 0xFFFF, and SP ends at 0xFFFF.
- **Condition outcomes:** each operation runs with its condition both holding and failing. The bench records the per-cycle bus-type trace and compares it with the expected ordering.

// File: rtl/ctlx_pkg.sv
package ctlx_pkg;

    typedef enum logic [2:0] {
        OP_JP   = 3'd0,
        OP_JR   = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_RETI = 3'd4,
        OP_RST  = 3'd5,
        OP_JHL  = 3'd6,
        OP_NONE = 3'd7
    } xfer_op_e;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_RD   = 2'd1,
        BK_WR   = 2'd2,
        BK_RSVD = 2'd3
    } bus_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_COND,
        ST_OPLO,
        ST_OPHI,
        ST_STKLO,
        ST_STKHI,
        ST_PREP,
        ST_PUSHH,
        ST_PUSHL,
        ST_FIN,
        ST_HLJ
    } seq_state_e;

    localparam logic [2:0] CC_ALWAYS = 3'd0;
    localparam logic [2:0] CC_CSET   = 3'd1;
    localparam logic [2:0] CC_ZSET   = 3'd2;
    localparam logic [2:0] CC_CCLR   = 3'd3;
    localparam logic [2:0] CC_ZCLR   = 3'd4;

endpackage

// File: rtl/ctlx_cond.sv
module ctlx_cond
    import ctlx_pkg::*;
(
    input  logic [2:0] cond_code,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       hit,
    output logic       uncond
);

    always_comb begin
        hit    = 1'b1;
        uncond = 1'b0;
        case (cond_code)
            CC_CSET: hit = flag_c;
            CC_ZSET: hit = flag_z;
            CC_CCLR: hit = ~flag_c;
            CC_ZCLR: hit = ~flag_z;
            default: begin
                hit    = 1'b1;
                uncond = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ctlx_fsm.sv
module ctlx_fsm
    import ctlx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  xfer_op_e   op_in,
    input  logic       cond_hit,
    input  logic       cond_uncond,
    output seq_state_e state,
    output xfer_op_e   op_q,
    output logic       accept,
    output logic       done,
    output logic       busy
);

    seq_state_e nxt;
    logic       taken_q;

    assign accept = start && (state == ST_IDLE) && (op_in != OP_NONE);

    // State register, captured operation and branch outcome.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_NONE;
            taken_q <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                op_q    <= op_in;
                taken_q <= (op_in == OP_RETI) ? 1'b1 : cond_hit;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    case (op_in)
                        OP_JP, OP_JR, OP_CALL: nxt = ST_OPLO;
                        OP_RET:                nxt = cond_uncond ? ST_STKLO : ST_COND;
                        OP_RETI:               nxt = ST_STKLO;
                        OP_RST:                nxt = ST_PREP;
                        OP_JHL:                nxt = ST_HLJ;
                        default:               nxt = ST_IDLE;
                    endcase
                end
            end
            ST_OPLO: begin
                if (op_q == OP_JR) nxt = taken_q ? ST_FIN : ST_IDLE;
                else               nxt = ST_OPHI;
            end
            ST_OPHI: begin
                if (!taken_q)              nxt = ST_IDLE;
                else if (op_q == OP_CALL)  nxt = ST_PREP;
                else                       nxt = ST_FIN;
            end
            ST_COND:  nxt = taken_q ? ST_STKLO : ST_IDLE;
            ST_STKLO: nxt = ST_STKHI;
            ST_STKHI: nxt = ST_FIN;
            ST_PREP:  nxt = ST_PUSHH;
            ST_PUSHH: nxt = ST_PUSHL;
            ST_PUSHL: nxt = ST_IDLE;
            ST_FIN:   nxt = ST_IDLE;
            ST_HLJ:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Status outputs.
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state != ST_IDLE) && (nxt == ST_IDLE);
    end

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R9
    hlj_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HLJ) |-> done);

endmodule

// File: rtl/ctlx_dpath.sv
module ctlx_dpath
    import ctlx_pkg::*;
#(
    parameter  int AW = 16,
    localparam int DW = AW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  seq_state_e    state,
    input  xfer_op_e      op_q,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] hl_in,
    input  logic [2:0]    vec_in,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output bus_kind_e     bus_kind,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] sp_q,
    output logic          irq_en
);

    logic [AW-1:0] tmp_q;
    logic [AW-1:0] hl_q;
    logic [2:0]    vec_q;
    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] vec_tgt;
    logic [AW-1:0] sp_dec;

    assign rel_tgt = pc_q + {{(AW-DW){tmp_q[DW-1]}}, tmp_q[DW-1:0]};
    assign vec_tgt = {{(AW-6){1'b0}}, vec_q, 3'b000};
    assign sp_dec  = sp_q - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            sp_q   <= '0;
            tmp_q  <= '0;
            hl_q   <= '0;
            vec_q  <= '0;
            irq_en <= 1'b0;
        end else begin
            if (accept) begin
                pc_q  <= pc_in;
                sp_q  <= sp_in;
                hl_q  <= hl_in;
                vec_q <= vec_in;
            end
            unique case (state)
                ST_OPLO: begin
                    tmp_q[DW-1:0] <= rdata;
                    pc_q          <= pc_q + 1'b1;
                end
                ST_OPHI: begin
                    tmp_q[AW-1:DW] <= rdata;
                    pc_q           <= pc_q + 1'b1;
                end
                ST_STKLO: begin
                    tmp_q[DW-1:0] <= rdata;
                    sp_q          <= sp_q + 1'b1;
                end
                ST_STKHI: begin
                    tmp_q[AW-1:DW] <= rdata;
                    sp_q           <= sp_q + 1'b1;
                end
                ST_PUSHH: sp_q <= sp_dec;
                ST_PUSHL: begin
                    sp_q <= sp_dec;
                    pc_q <= (op_q == OP_RST) ? vec_tgt : tmp_q;
                end
                ST_FIN: begin
                    pc_q <= (op_q == OP_JR) ? rel_tgt : tmp_q;
                    if (op_q == OP_RETI) irq_en <= 1'b1;
                end
                ST_HLJ:  pc_q <= hl_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_kind  = BK_IDLE;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_OPLO, ST_OPHI: begin
                bus_kind = BK_RD;
                bus_addr = pc_q;
            end
            ST_STKLO, ST_STKHI: begin
                bus_kind = BK_RD;
                bus_addr = sp_q;
            end
            ST_PUSHH: begin
                bus_kind  = BK_WR;
                bus_addr  = sp_dec;
                bus_wdata = pc_q[AW-1:DW];
            end
            ST_PUSHL: begin
                bus_kind  = BK_WR;
                bus_addr  = sp_dec;
                bus_wdata = pc_q[DW-1:0];
            end
            default: ;
        endcase
    end

    // R5
    wr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_kind == BK_WR) |=> (sp_q == $past(sp_q) - 1'b1));

    // R6
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STKHI) |=> (sp_q == $past(sp_q) + 1'b1));

    // R7
    ie_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(irq_en));

    // R8
    rst_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSHL && op_q == OP_RST) |=>
            (pc_q[2:0] == 3'b000 && pc_q[AW-1:6] == '0));

endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq
    import ctlx_pkg::*;
#(
    parameter  int ADDR_W = 16,
    localparam int DATA_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [2:0]        cond,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [2:0]        vec_sel,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] hl_in,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [1:0]        bus_kind,
    output logic              done,
    output logic              busy,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic              irq_en
);

    seq_state_e state;
    xfer_op_e   op_q;
    logic       accept;
    logic       cond_hit;
    logic       cond_uncond;
    bus_kind_e  kind;

    ctlx_cond u_cond (
        .cond_code (cond),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .hit       (cond_hit),
        .uncond    (cond_uncond)
    );

    ctlx_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op_in       (xfer_op_e'(op)),
        .cond_hit    (cond_hit),
        .cond_uncond (cond_uncond),
        .state       (state),
        .op_q        (op_q),
        .accept      (accept),
        .done        (done),
        .busy        (busy)
    );

    ctlx_dpath #(.AW(ADDR_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .state     (state),
        .op_q      (op_q),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .hl_in     (hl_in),
        .vec_in    (vec_sel),
        .rdata     (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_kind  (kind),
        .pc_q      (pc_out),
        .sp_q      (sp_out),
        .irq_en    (irq_en)
    );

    assign bus_kind = kind;

    // R10
    bus_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_kind != 2'd0) |-> busy);

    // R5
    wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_kind == 2'd2 && !done) |=> (bus_kind == 2'd2 && done));

endmodule

// File: tb/ctl_xfer_seq_tb.sv
module ctl_xfer_seq_tb_top;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  cc;
        logic        z;
        logic        c;
        logic [2:0]  vec;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [3:0]  cyc;
        logic [11:0] kinds;
        logic [15:0] epc;
        logic [15:0] esp;
        logic        wr;
        logic [7:0]  whi;
        logic [7:0]  wlo;
    } vec_t;

    localparam int NV = 20;
    // Bus-kind trace: two bits per cycle, first cycle in bits [1:0]; 0 idle, 1 read, 2 write.
    localparam vec_t TBL [NV] = '{
        '{3'd0,3'd0,1'b0,1'b0,3'd0,16'h1210,16'hC080,8'h34,8'h12,4'd3,12'h005,16'h1234,16'hC080,1'b0,8'h00,8'h00}, // R3 taken
        '{3'd0,3'd2,1'b0,1'b0,3'd0,16'h1210,16'hC080,8'h34,8'h12,4'd2,12'h005,16'h1212,16'hC080,1'b0,8'h00,8'h00}, // R3 R1 not taken
        '{3'd0,3'd3,1'b0,1'b0,3'd0,16'h1210,16'hC080,8'hCD,8'hAB,4'd3,12'h005,16'hABCD,16'hC080,1'b0,8'h00,8'h00}, // R1 carry clear
        '{3'd1,3'd0,1'b0,1'b0,3'd0,16'h1210,16'hC080,8'h05,8'h00,4'd2,12'h001,16'h1216,16'hC080,1'b0,8'h00,8'h00}, // R4 forward
        '{3'd1,3'd1,1'b0,1'b1,3'd0,16'h1210,16'hC080,8'hF0,8'h00,4'd2,12'h001,16'h1201,16'hC080,1'b0,8'h00,8'h00}, // R4 backward
        '{3'd1,3'd4,1'b1,1'b0,3'd0,16'h1210,16'hC080,8'hF0,8'h00,4'd1,12'h001,16'h1211,16'hC080,1'b0,8'h00,8'h00}, // R4 not taken
        '{3'd1,3'd0,1'b0,1'b0,3'd0,16'h1210,16'hC080,8'h80,8'h00,4'd2,12'h001,16'h1191,16'hC080,1'b0,8'h00,8'h00}, // R4 -128
        '{3'd2,3'd0,1'b0,1'b0,3'd0,16'h5610,16'hC080,8'h00,8'h30,4'd5,12'h285,16'h3000,16'hC07E,1'b1,8'h56,8'h12}, // R5 taken
        '{3'd2,3'd2,1'b0,1'b0,3'd0,16'h5610,16'hC080,8'h00,8'h30,4'd2,12'h005,16'h5612,16'hC080,1'b0,8'h00,8'h00}, // R5 not taken
        '{3'd3,3'd0,1'b0,1'b0,3'd0,16'h1210,16'hC080,8'h78,8'h56,4'd3,12'h005,16'h5678,16'hC082,1'b0,8'h00,8'h00}, // R6 unconditional
        '{3'd3,3'd1,1'b0,1'b1,3'd0,16'h1210,16'hC080,8'h78,8'h56,4'd4,12'h014,16'h5678,16'hC082,1'b0,8'h00,8'h00}, // R6 cond taken
        '{3'd3,3'd3,1'b0,1'b1,3'd0,16'h1210,16'hC080,8'h78,8'h56,4'd1,12'h000,16'h1210,16'hC080,1'b0,8'h00,8'h00}, // R6 cond fails
        '{3'd4,3'd0,1'b0,1'b0,3'd0,16'h1210,16'hC080,8'h78,8'h56,4'd3,12'h005,16'h5678,16'hC082,1'b0,8'h00,8'h00}, // R7
        '{3'd5,3'd0,1'b0,1'b0,3'd5,16'h1210,16'hC080,8'h00,8'h00,4'd3,12'h028,16'h0028,16'hC07E,1'b1,8'h12,8'h10}, // R8 vec 5
        '{3'd6,3'd0,1'b0,1'b0,3'd0,16'h1210,16'hC080,8'h00,8'h00,4'd1,12'h000,16'h4567,16'hC080,1'b0,8'h00,8'h00}, // R9
        '{3'd5,3'd0,1'b0,1'b0,3'd7,16'hBE10,16'hC080,8'h00,8'h00,4'd3,12'h028,16'h0038,16'hC07E,1'b1,8'hBE,8'h10}, // R8 vec 7
        '{3'd2,3'd0,1'b0,1'b0,3'd0,16'h9A10,16'h0001,8'h11,8'h22,4'd5,12'h285,16'h2211,16'hFFFF,1'b1,8'h9A,8'h12}, // R11 wrap
        '{3'd0,3'd2,1'b1,1'b0,3'd0,16'h1210,16'hC080,8'h34,8'h12,4'd3,12'h005,16'h1234,16'hC080,1'b0,8'h00,8'h00}, // R1 zero set
        '{3'd1,3'd3,1'b0,1'b1,3'd0,16'h1210,16'hC080,8'h05,8'h00,4'd1,12'h001,16'h1211,16'hC080,1'b0,8'h00,8'h00}, // R1 carry clear fails
        '{3'd0,3'd6,1'b0,1'b0,3'd0,16'h1210,16'hC080,8'h34,8'h12,4'd3,12'h005,16'h1234,16'hC080,1'b0,8'h00,8'h00}  // R1 code 6 = always
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [2:0]  cond = 3'd0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [2:0]  vec_sel = 3'd0;
    logic [15:0] pc_in = 16'h0;
    logic [15:0] sp_in = 16'h0;
    logic [15:0] hl_in = 16'h4567;
    logic [7:0]  bus_rdata = 8'h0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [1:0]  bus_kind;
    logic        done;
    logic        busy;
    logic [15:0] pc_out;
    logic [15:0] sp_out;
    logic        irq_en;

    logic [7:0]  mem [256];
    int          n_chk = 0;
    int          n_bad = 0;
    logic        ie_exp = 1'b0;

    always #10 clk = ~clk;

    ctl_xfer_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .cond      (cond),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .vec_sel   (vec_sel),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .hl_in     (hl_in),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_kind  (bus_kind),
        .done      (done),
        .busy      (busy),
        .pc_out    (pc_out),
        .sp_out    (sp_out),
        .irq_en    (irq_en)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int idx, input bit poke);
        vec_t        v;
        logic [11:0] kinds;
        int          n;
        logic [15:0] a_hi;
        logic [15:0] a_lo;
        v     = TBL[idx];
        kinds = '0;
        n     = 0;
        a_hi  = v.sp - 16'd1;
        a_lo  = v.sp - 16'd2;
        mem[v.pc[7:0]]         = v.b0;
        mem[v.pc[7:0] + 8'd1]  = v.b1;
        mem[v.sp[7:0]]         = v.b0;
        mem[v.sp[7:0] + 8'd1]  = v.b1;
        mem[a_hi[7:0]]         = 8'h00;
        mem[a_lo[7:0]]         = 8'h00;
        @(negedge clk);
        op = v.op; cond = v.cc; flag_z = v.z; flag_c = v.c;
        vec_sel = v.vec; pc_in = v.pc; sp_in = v.sp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (poke && n == 0) begin
                op = 3'd6;
                start = 1'b1;
            end
            if (poke && n == 1) start = 1'b0;
            if (n < 6) kinds = kinds | (12'(bus_kind) << (2 * n));
            if (bus_kind == 2'd1) bus_rdata = mem[bus_addr[7:0]];
            if (bus_kind == 2'd2) mem[bus_addr[7:0]] = bus_wdata;
            n++;
            if (done || n > 12) break;
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        if (v.op == 3'd4) ie_exp = 1'b1;
        chk("R10", $sformatf("vec%0d cycles", idx), 32'(n), 32'(v.cyc));
        chk("R2", $sformatf("vec%0d bus trace", idx), 32'(kinds), 32'(v.kinds));
        chk("R3", $sformatf("vec%0d pc_out", idx), 32'(pc_out), 32'(v.epc));
        chk("R6", $sformatf("vec%0d sp_out", idx), 32'(sp_out), 32'(v.esp));
        chk("R7", $sformatf("vec%0d irq_en", idx), 32'(irq_en), 32'(ie_exp));
        chk("R10", $sformatf("vec%0d busy after done", idx), 32'(busy), 32'd0);
        if (v.wr) begin
            chk("R5", $sformatf("vec%0d pushed high", idx), 32'(mem[a_hi[7:0]]), 32'(v.whi));
            chk("R8", $sformatf("vec%0d pushed low", idx), 32'(mem[a_lo[7:0]]), 32'(v.wlo));
        end
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "reset busy", 32'(busy), 32'd0);
        chk("R10", "reset done", 32'(done), 32'd0);
        chk("R10", "reset bus_kind", 32'(bus_kind), 32'd0);
        chk("R10", "reset irq_en", 32'(irq_en), 32'd0);
        chk("R10", "reset pc_out", 32'(pc_out), 32'd0);
        chk("R10", "reset sp_out", 32'(sp_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

        // R2: a start raised mid-sequence with another op must not disturb a jump
        run_vec(0, 1'b1);

        // R2: op code 7 is ignored
        @(negedge clk);
        op = 3'd7; start = 1'b1; pc_in = 16'h7777; sp_in = 16'h7777;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "op7 busy", 32'(busy), 32'd0);
        chk("R2", "op7 bus_kind", 32'(bus_kind), 32'd0);
        @(negedge clk);
        chk("R2", "op7 pc_out kept", 32'(pc_out), 32'h1234);
        chk("R2", "op7 sp_out kept", 32'(sp_out), 32'hC080);

        // R7: irq_en cleared only by reset
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7", "irq_en after reset", 32'(irq_en), 32'd0);
        chk("R10", "pc_out after reset", 32'(pc_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule